// File: doc/BRIEF.md
# Program Counter and Address Unit

This block produces the 16-bit address of the next memory access of a small pipelined processor. The address comes from one of three sources: the program counter advanced by a step, an effective-address sum computed elsewhere in the datapath, or a forced zero used at reset. The step is +2 for straight-line fetch, or twice a sign-extended 8-bit displacement for a taken relative branch. A single adder serves both cases.

The program counter lives in a small slot store rather than a plain register. Slot 0 is the processor program counter and slot 1 is a DMA pointer. A select input chooses which slot is read and advanced, so DMA walks memory through the same increment path. When the PC enable is set, the chosen address is written back into the selected slot. For jumps and calls the control unit routes the effective-address sum through the mux with the enable set. A call target is formed upstream as a 12-bit field shifted left by four, so callees sit on 16-byte boundaries.

A separate return-address register captures the selected slot under its own enable, for later writing to a link register. Branch condition evaluation and the memory bus controller are outside this block.

Top module: `pc_addr_unit`

## Requirements
- R1: While reset is asserted (rst_ni low) and after its release, every slot holds 0 and ret_addr_o is 0.
- R2: With zero_pc_i=0, sel_pc_i=1 and branch_i=0, addr_o equals the selected slot plus 2, modulo 2^16.
- R3: With zero_pc_i=0, sel_pc_i=1 and branch_i=1, addr_o equals the selected slot plus two times disp_i read as an 8-bit two's-complement number, modulo 2^16.
- R4: When pc_we_i=1 at a rising edge, the selected slot takes addr_o with bit 0 cleared. With PC=6 and no branch, addr_o is 8 and the PC then becomes 8.
- R5: With zero_pc_i=0 and sel_pc_i=0, addr_o equals ea_sum_i. With pc_we_i=0, no slot changes. With pc_we_i=1, this is a jump and the slot loads ea_sum_i.
- R6: zero_pc_i=1 forces addr_o to 0 regardless of the other inputs. With pc_we_i=1 the selected slot becomes 0.
- R7: dma_sel_i=0 selects slot 0 (CPU PC) and dma_sel_i=1 selects slot 1 (DMA pointer), both for reading and for write-back. The unselected slot never changes.
- R8: When ret_ce_i=1 at a rising edge, ret_addr_o takes the selected slot's value before that edge. Otherwise ret_addr_o holds its value.
- R9: Bit 0 of every slot is always 0, even after a jump to an odd effective address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| branch_i | input | 1 | 1: step is twice the displacement; 0: step is +2 |
| disp_i | input | 8 | Signed branch displacement in instruction words |
| ea_sum_i | input | 16 | Effective-address sum from the execution adder |
| sel_pc_i | input | 1 | 1: address is the stepped PC; 0: address is ea_sum_i |
| zero_pc_i | input | 1 | Forces the address to zero |
| dma_sel_i | input | 1 | Slot select: 0 CPU PC, 1 DMA pointer |
| pc_we_i | input | 1 | Writes the address back into the selected slot |
| ret_ce_i | input | 1 | Captures the selected slot into the return register |
| addr_o | output | 16 | Next memory address (combinational) |
| ret_addr_o | output | 16 | Saved return address |

## Verification
On every cycle, the assertions check the following behaviours: the zero override and the effective-address pass-through at the address port, write-back of the address into exactly the selected slot, retention of all slots when the enable is low, the even alignment of stored values, and the return-register capture. The arithmetic of the step cannot be shown by the assertions. This covers sign extension of the displacement, wrap-around at the top of the address space, and the worked PC=6 to 8 case. The bench shows it by sweeping all 256 displacements from several base addresses and by walking the PC across the 0xFFFE boundary. It also computes every expected address arithmetically.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_SEQ  = 2'd1,
        SRC_EA   = 2'd2
    } addr_src_e;

endpackage

// File: rtl/pcu_step.sv
module pcu_step #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          branch_i,
    input  logic [DW-1:0] disp_i,
    output logic [AW-1:0] step_o
);
    localparam int EXT_W = AW - DW - 1;

    logic [AW-1:0] br_step;

    // sign-extend the word displacement and scale to bytes
    assign br_step = {{EXT_W{disp_i[DW-1]}}, disp_i, 1'b0};

    always_comb begin
        if (branch_i) step_o = br_step;
        else          step_o = AW'(2);
    end
endmodule

// File: rtl/pcu_incr.sv
module pcu_incr #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] step_i,
    output logic [AW-1:0] sum_o
);
    // modulo 2^AW; carry out is dropped on purpose
    assign sum_o = base_i + step_i;
endmodule

// File: rtl/pcu_slots.sv
module pcu_slots #(
    parameter int AW      = 16,
    parameter int N_SLOTS = 2,
    parameter int IW      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  we_i,
    input  logic [IW-1:0]         idx_i,
    input  logic [AW-1:0]         wdata_i,
    output logic [AW-1:0]         rdata_o,
    output logic [N_SLOTS*AW-1:0] flat_o
);
    logic [AW-1:0] slot_q [N_SLOTS];

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                slot_q[g] <= '0;
            end else if (we_i && (idx_i == IW'(g))) begin
                slot_q[g] <= wdata_i;
            end
        end
        assign flat_o[g*AW +: AW] = slot_q[g];
    end

    assign rdata_o = slot_q[idx_i];
endmodule

// File: rtl/pcu_ret.sv
module pcu_ret #(
    parameter int AW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ce_i,
    input  logic [AW-1:0] d_i,
    output logic [AW-1:0] q_o
);
    always_ff @(posedge clk_i) begin
        if (!rst_ni)   q_o <= '0;
        else if (ce_i) q_o <= d_i;
    end
endmodule

// File: rtl/pc_addr_unit.sv
module pc_addr_unit
    import pcu_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int N_SLOTS = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          branch_i,
    input  logic [DW-1:0] disp_i,
    input  logic [AW-1:0] ea_sum_i,
    input  logic          sel_pc_i,
    input  logic          zero_pc_i,
    input  logic          dma_sel_i,
    input  logic          pc_we_i,
    input  logic          ret_ce_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] ret_addr_o
);
    localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    addr_src_e             src;
    logic [IW-1:0]         slot_idx;
    logic [AW-1:0]         cur_pc;
    logic [AW-1:0]         step;
    logic [AW-1:0]         next_pc;
    logic [AW-1:0]         wb_data;
    logic [N_SLOTS*AW-1:0] slot_flat;

    assign slot_idx = IW'(dma_sel_i);

    // source decode: zero beats everything, then PC path, then EA
    always_comb begin
        if (zero_pc_i)     src = SRC_ZERO;
        else if (sel_pc_i) src = SRC_SEQ;
        else               src = SRC_EA;
    end

    pcu_step #(.AW(AW), .DW(DW)) u_step (
        .branch_i (branch_i),
        .disp_i   (disp_i),
        .step_o   (step)
    );

    pcu_incr #(.AW(AW)) u_incr (
        .base_i (cur_pc),
        .step_i (step),
        .sum_o  (next_pc)
    );

    always_comb begin
        unique case (src)
            SRC_ZERO: addr_o = '0;
            SRC_SEQ:  addr_o = next_pc;
            SRC_EA:   addr_o = ea_sum_i;
            default:  addr_o = '0;
        endcase
    end

    // instruction addresses are halfword aligned
    assign wb_data = {addr_o[AW-1:1], 1'b0};

    pcu_slots #(.AW(AW), .N_SLOTS(N_SLOTS), .IW(IW)) u_slots (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (pc_we_i),
        .idx_i   (slot_idx),
        .wdata_i (wb_data),
        .rdata_o (cur_pc),
        .flat_o  (slot_flat)
    );

    pcu_ret #(.AW(AW)) u_ret (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ce_i   (ret_ce_i),
        .d_i    (cur_pc),
        .q_o    (ret_addr_o)
    );
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
    parameter int AW      = 16,
    parameter int N_SLOTS = 2
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  zero_pc_i,
    input logic                  sel_pc_i,
    input logic                  dma_sel_i,
    input logic                  pc_we_i,
    input logic                  ret_ce_i,
    input logic [AW-1:0]         ea_sum_i,
    input logic [AW-1:0]         addr_o,
    input logic [AW-1:0]         ret_addr_o,
    input logic [AW-1:0]         cur_pc,
    input logic [N_SLOTS*AW-1:0] slot_flat
);
    logic [AW-1:0] s0, s1;
    assign s0 = slot_flat[AW-1:0];
    assign s1 = slot_flat[2*AW-1:AW];

    a_r6_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_pc_i |-> addr_o == '0);

    a_r5_ea_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!zero_pc_i && !sel_pc_i) |-> addr_o == ea_sum_i);

    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pc_we_i |=> $stable(slot_flat));

    a_r4_wb_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_we_i && !dma_sel_i) |=> s0 == ($past(addr_o) & ~AW'(1)));

    a_r4_wb_slot1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_we_i && dma_sel_i) |=> s1 == ($past(addr_o) & ~AW'(1)));

    a_r7_slot1_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dma_sel_i |=> $stable(s1));

    a_r7_slot0_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_sel_i |=> $stable(s0));

    a_r9_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s0[0] == 1'b0) && (s1[0] == 1'b0));

    a_r8_ret_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_ce_i |=> ret_addr_o == $past(cur_pc));

    a_r8_ret_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ret_ce_i |=> $stable(ret_addr_o));
endmodule

bind pc_addr_unit pcu_chk #(.AW(AW), .N_SLOTS(N_SLOTS)) u_pcu_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zero_pc_i  (zero_pc_i),
    .sel_pc_i   (sel_pc_i),
    .dma_sel_i  (dma_sel_i),
    .pc_we_i    (pc_we_i),
    .ret_ce_i   (ret_ce_i),
    .ea_sum_i   (ea_sum_i),
    .addr_o     (addr_o),
    .ret_addr_o (ret_addr_o),
    .cur_pc     (cur_pc),
    .slot_flat  (slot_flat)
);

// File: tb/test_pc_addr_unit.sv
`timescale 1ns/1ps
module test_pc_addr_unit;
    logic        clk_i = 1'b0;
    logic        rst_ni;
    logic        branch_i, sel_pc_i, zero_pc_i, dma_sel_i, pc_we_i, ret_ce_i;
    logic [7:0]  disp_i;
    logic [15:0] ea_sum_i;
    logic [15:0] addr_o, ret_addr_o;

    int unsigned total = 0;
    int unsigned bad   = 0;
    logic [15:0] m_pc [2];
    logic [15:0] m_ret;

    always #2.5 clk_i = ~clk_i;

    pc_addr_unit i_pc_addr_unit (
        .clk_i(clk_i), .rst_ni(rst_ni), .branch_i(branch_i), .disp_i(disp_i),
        .ea_sum_i(ea_sum_i), .sel_pc_i(sel_pc_i), .zero_pc_i(zero_pc_i),
        .dma_sel_i(dma_sel_i), .pc_we_i(pc_we_i), .ret_ce_i(ret_ce_i),
        .addr_o(addr_o), .ret_addr_o(ret_addr_o)
    );

    function automatic logic [15:0] exp_addr();
        logic [15:0] step;
        if (zero_pc_i) return 16'h0000;
        if (!sel_pc_i) return ea_sum_i;
        step = branch_i ? 16'($signed(disp_i)) * 16'd2 : 16'd2;
        return m_pc[dma_sel_i] + step;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic br, logic [7:0] d, logic [15:0] ea, logic sel,
                         logic z, logic dma, logic we, logic rc);
        branch_i = br; disp_i = d; ea_sum_i = ea; sel_pc_i = sel;
        zero_pc_i = z; dma_sel_i = dma; pc_we_i = we; ret_ce_i = rc;
    endtask

    // inputs are set before calling, at a falling edge
    task automatic cyc(string tag);
        logic [15:0] a;
        #1;
        a = exp_addr();
        chk(tag, addr_o, a);
        @(posedge clk_i);
        if (ret_ce_i) m_ret = m_pc[dma_sel_i];
        if (pc_we_i)  m_pc[dma_sel_i] = {a[15:1], 1'b0};
        @(negedge clk_i);
        chk("R8", ret_addr_o, m_ret);
    endtask

    task automatic jump(logic dma, logic [15:0] tgt);
        drive(0, 8'h00, tgt, 0, 0, dma, 1, 0);
        cyc("R5");
    endtask

    initial begin
        rst_ni = 1'b0;
        m_pc[0] = '0; m_pc[1] = '0; m_ret = '0;
        drive(0, 8'h00, 16'h0000, 1, 0, 0, 0, 0);
        repeat (3) @(negedge clk_i);
        chk("R1", ret_addr_o, 16'h0000);
        rst_ni = 1'b1;
        @(negedge clk_i);
        #1 chk("R1", addr_o, 16'h0002);
        dma_sel_i = 1; #1 chk("R1", addr_o, 16'h0002);

        // worked example: PC=6 -> 8
        jump(0, 16'h0006);
        drive(0, 8'h00, 16'h0000, 1, 0, 0, 1, 0);
        #1 chk("R4", addr_o, 16'h0008);
        cyc("R4");
        drive(0, 8'h00, 16'h0000, 1, 0, 0, 0, 1);
        cyc("R4");
        chk("R4", ret_addr_o, 16'h0008);

        // R3: all displacements from several bases
        foreach (m_pc[k]) begin end
        for (int b = 0; b < 5; b++) begin
            logic [15:0] base;
            case (b)
                0: base = 16'h0000; 1: base = 16'h0100; 2: base = 16'h7FFE;
                3: base = 16'hFFFE; default: base = 16'h8000;
            endcase
            jump(0, base);
            for (int d = 0; d < 256; d++) begin
                drive(1, 8'(d), 16'h1234, 1, 0, 0, 0, 0);
                cyc("R3");
            end
            drive(1, 8'h80, 16'h0000, 1, 0, 0, 1, 0);
            cyc("R3");
            drive(1, 8'h7F, 16'h0000, 1, 0, 0, 1, 1);
            cyc("R3");
        end

        // R2: sequential walk across the wrap
        jump(0, 16'hFF00);
        for (int i = 0; i < 300; i++) begin
            drive(0, 8'hA5, 16'h5555, 1, 0, 0, 1, (i % 7) == 0);
            cyc("R2");
        end

        // R5: EA pass-through without write-back leaves PC alone
        for (int i = 0; i < 64; i++) begin
            drive(1, 8'(i), 16'(i * 1031 + 3), 0, 0, i[0], 0, 0);
            cyc("R5");
        end
        drive(0, 8'h00, 16'h0000, 1, 0, 0, 0, 0);
        cyc("R5");
        // R9: odd jump target stored even
        jump(0, 16'h4321);
        drive(0, 8'h00, 16'h0000, 0, 0, 0, 0, 1);
        cyc("R9");
        chk("R9", ret_addr_o, 16'h4320);

        // R6: zero override
        for (int i = 0; i < 16; i++) begin
            drive(i[0], 8'(i * 17), 16'(i * 4099), i[1], 1, i[2], i[3], 0);
            cyc("R6");
        end
        drive(0, 8'h00, 16'h0000, 0, 0, 0, 0, 1);
        cyc("R6");

        // R7: DMA slot independent of CPU slot
        jump(0, 16'h2000);
        jump(1, 16'hC000);
        for (int i = 0; i < 20; i++) begin
            drive(i[2], 8'(i * 3), 16'h0000, 1, 0, i[0], 1, i[1]);
            cyc("R7");
        end
        drive(0, 8'h00, 16'h0000, 1, 0, 0, 0, 1);
        cyc("R7");
        drive(0, 8'h00, 16'h0000, 1, 0, 1, 0, 1);
        cyc("R7");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule